// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This unit sits behind the instruction decoder of a pipelined integer core. For each accepted request it is given a condition code, two 32-bit register operands, a 16-bit immediate, eight floating-point condition flags and the address of the instruction. One cycle later it reports three things. The first is whether a branch is taken. The second is whether a conditional move may commit. The third is whether a trap must be raised. For the linking branch forms it also reports a write request to register 31 that carries the return address, which is the instruction address plus 8.

The unit covers several groups of conditions:
- register-to-register equality and inequality;
- signed comparisons of one operand against zero;
- trap comparisons, signed and unsigned, against a second register or against the sign-extended immediate;
- branches and moves that test one of the eight flags;
- moves that depend on whether a register is zero.

The core computes branch targets, flushes the pipeline and vectors exceptions. None of that is done here.

A two-state machine sequences the output register:
- ST_IDLE means no result is being presented. ST_DONE means the output register holds the verdict for the request accepted on the previous edge.
- Transition ACCEPT (ST_IDLE to ST_DONE) fires when in_valid is high.
- Transition CHAIN (ST_DONE to ST_DONE) fires when in_valid is high again.
- Transition DRAIN (ST_DONE to ST_IDLE) fires when in_valid is low.

Top module: `cond_eval_unit`

## Requirements
- R1: While rst_n is low, and on every edge that accepts no request, res_valid, br_taken, mv_en, trap_req and link_we all read 0 afterwards.
- R2: Code 1 sets br_taken when rs_val equals rt_val. Code 2 sets br_taken when they differ.
- R3: Codes 3, 4, 5 and 6 set br_taken when rs_val, read as a signed value, is respectively >= 0, > 0, <= 0 or < 0.
- R4: Codes 7 (>= 0) and 8 (< 0) are linking forms of the signed zero tests. When their condition holds they set br_taken and link_we, set link_idx to 31 and set link_addr to pc + 8. When it fails, link_we stays 0.
- R5: Register trap codes set trap_req when their condition between rs_val and rt_val holds. The codes are 9 equal, 10 not equal, 11 signed >=, 12 unsigned >=, 13 signed < and 14 unsigned <.
- R6: Immediate trap codes 15 to 20 test the same six conditions, in the same order, against imm sign-extended to 32 bits. The unsigned forms (18 and 20) compare unsigned against that sign-extended value, so an immediate of 0xFFFF stands for 0xFFFFFFFF.
- R7: Flag codes select flag fcc[imm[2:0]]. An immediate index of 0 selects fcc[0]. Code 21 branches if the flag is 1 and code 22 branches if it is 0. Code 23 enables a move if the flag is 1 and code 24 enables a move if it is 0.
- R8: Code 25 sets mv_en when rt_val is zero. Code 26 sets mv_en when rt_val is non-zero.
- R9: A request sampled with in_valid high on an edge produces its verdict, with res_valid high, on that edge. The verdict lasts for exactly one cycle, so trap_req is a single-cycle pulse per trapping request, and back-to-back requests each get their own verdict.
- R10: At most one of br_taken, mv_en and trap_req is high. Code 0 and codes 27 to 31 produce no action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 5 | Condition code, encoded as listed in the requirements |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand, also the operand tested by the zero/non-zero moves |
| imm | input | 16 | Immediate; bits 2:0 also select the flag |
| fcc | input | 8 | Floating-point condition flags |
| pc | input | 32 | Address of the instruction being evaluated |
| res_valid | output | 1 | Verdict present this cycle |
| br_taken | output | 1 | Branch condition true |
| mv_en | output | 1 | Conditional move may commit |
| trap_req | output | 1 | Trap condition true (one-cycle pulse) |
| link_we | output | 1 | Write return address to the link register |
| link_idx | output | 5 | Link register index (31 when link_we is high, else 0) |
| link_addr | output | 32 | Return address (pc + 8) when link_we is high, else 0 |

## Verification
The bench drives every code with the operand pairs formed from 0x7FFFFFFF, 0x80000000, 0 and 0xFFFFFFFF. At these values a comparator that swaps signed and unsigned gives the wrong answer. A zero test that forgets the sign bit calls 0x80000000 positive. A greater-than-zero test that omits the zero check branches on 0. Immediate traps are given 0xFFFF and 0x8000. An evaluator that zero-extends the immediate would treat 0xFFFF as 65535, so the unsigned less-than test would fail for 0x7FFFFFFF. The flag tests use index 0 and index 7. The directed cases check that the verdict lasts exactly one cycle, so a trap held into the next request would show up, and that the link address is exactly pc + 8 with no link write when the condition fails.

// File: rtl/cev_pkg.sv
package cev_pkg;

    typedef enum logic [4:0] {
        OP_NONE       = 5'd0,
        OP_REG_EQ     = 5'd1,
        OP_REG_NE     = 5'd2,
        OP_GEZ        = 5'd3,
        OP_GTZ        = 5'd4,
        OP_LEZ        = 5'd5,
        OP_LTZ        = 5'd6,
        OP_GEZ_LNK    = 5'd7,
        OP_LTZ_LNK    = 5'd8,
        OP_TR_EQ      = 5'd9,
        OP_TR_NE      = 5'd10,
        OP_TR_GE      = 5'd11,
        OP_TR_GEU     = 5'd12,
        OP_TR_LT      = 5'd13,
        OP_TR_LTU     = 5'd14,
        OP_TI_EQ      = 5'd15,
        OP_TI_NE      = 5'd16,
        OP_TI_GE      = 5'd17,
        OP_TI_GEU     = 5'd18,
        OP_TI_LT      = 5'd19,
        OP_TI_LTU     = 5'd20,
        OP_FLAG_BR_T  = 5'd21,
        OP_FLAG_BR_F  = 5'd22,
        OP_FLAG_MV_T  = 5'd23,
        OP_FLAG_MV_F  = 5'd24,
        OP_MV_ZERO    = 5'd25,
        OP_MV_NZERO   = 5'd26
    } cond_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic br;
        logic mv;
        logic tr;
        logic lk;
    } verdict_t;

endpackage

// File: rtl/cev_compare.sv
module cev_compare #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            is_eq,
    output logic            is_lt_s,
    output logic            is_lt_u
);
    logic [XLEN:0] diff;

    // one subtractor gives both orderings: borrow for unsigned, sign/overflow for signed
    always_comb begin
        diff    = {1'b0, opa} - {1'b0, opb};
        is_eq   = (opa == opb);
        is_lt_u = diff[XLEN];
        if (opa[XLEN-1] != opb[XLEN-1]) begin
            is_lt_s = opa[XLEN-1];
        end else begin
            is_lt_s = diff[XLEN];
        end
    end
endmodule

// File: rtl/cev_flag_pick.sv
module cev_flag_pick #(
    parameter int unsigned FLAG_N = 8,
    localparam int unsigned SEL_W = (FLAG_N > 1) ? $clog2(FLAG_N) : 1
) (
    input  logic [FLAG_N-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              picked
);
    logic [FLAG_N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < FLAG_N; g++) begin : g_hit
            assign hit[g] = flags[g] && (sel == SEL_W'(g));
        end
    endgenerate

    assign picked = |hit;
endmodule

// File: rtl/cev_decide.sv
module cev_decide
    import cev_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  cond_op_e        op,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            r_eq,
    input  logic            r_lt_s,
    input  logic            r_lt_u,
    input  logic            i_eq,
    input  logic            i_lt_s,
    input  logic            i_lt_u,
    input  logic            flag_bit,
    output verdict_t        verdict
);
    logic rs_neg;
    logic rs_zero;
    logic rt_zero;

    always_comb begin
        rs_neg  = rs_val[XLEN-1];
        rs_zero = (rs_val == '0);
        rt_zero = (rt_val == '0);
    end

    always_comb begin
        verdict = '0;
        unique case (op)
            OP_REG_EQ:    verdict.br = r_eq;
            OP_REG_NE:    verdict.br = !r_eq;
            OP_GEZ:       verdict.br = !rs_neg;
            OP_GTZ:       verdict.br = !rs_neg && !rs_zero;
            OP_LEZ:       verdict.br = rs_neg || rs_zero;
            OP_LTZ:       verdict.br = rs_neg;
            OP_GEZ_LNK: begin
                verdict.br = !rs_neg;
                verdict.lk = !rs_neg;
            end
            OP_LTZ_LNK: begin
                verdict.br = rs_neg;
                verdict.lk = rs_neg;
            end
            OP_TR_EQ:     verdict.tr = r_eq;
            OP_TR_NE:     verdict.tr = !r_eq;
            OP_TR_GE:     verdict.tr = !r_lt_s;
            OP_TR_GEU:    verdict.tr = !r_lt_u;
            OP_TR_LT:     verdict.tr = r_lt_s;
            OP_TR_LTU:    verdict.tr = r_lt_u;
            OP_TI_EQ:     verdict.tr = i_eq;
            OP_TI_NE:     verdict.tr = !i_eq;
            OP_TI_GE:     verdict.tr = !i_lt_s;
            OP_TI_GEU:    verdict.tr = !i_lt_u;
            OP_TI_LT:     verdict.tr = i_lt_s;
            OP_TI_LTU:    verdict.tr = i_lt_u;
            OP_FLAG_BR_T: verdict.br = flag_bit;
            OP_FLAG_BR_F: verdict.br = !flag_bit;
            OP_FLAG_MV_T: verdict.mv = flag_bit;
            OP_FLAG_MV_F: verdict.mv = !flag_bit;
            OP_MV_ZERO:   verdict.mv = rt_zero;
            OP_MV_NZERO:  verdict.mv = !rt_zero;
            default:      verdict = '0;
        endcase
    end
endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
    import cev_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned IMM_W     = 16,
    parameter int unsigned FLAG_N    = 8,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned LINK_REG  = 31,
    parameter int unsigned LINK_OFS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [4:0]           op_code,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    input  logic [IMM_W-1:0]     imm,
    input  logic [FLAG_N-1:0]    fcc,
    input  logic [XLEN-1:0]      pc,
    output logic                 res_valid,
    output logic                 br_taken,
    output logic                 mv_en,
    output logic                 trap_req,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_addr
);
    localparam int unsigned SEL_W  = (FLAG_N > 1) ? $clog2(FLAG_N) : 1;
    localparam int unsigned N_CMP  = 2;

    cond_op_e        op;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] cmp_b   [N_CMP];
    logic            cmp_eq  [N_CMP];
    logic            cmp_lts [N_CMP];
    logic            cmp_ltu [N_CMP];
    logic            flag_bit;
    verdict_t        verdict_nxt;
    verdict_t        verdict_q;
    logic [XLEN-1:0] ret_addr_q;
    seq_state_e      state_q;
    seq_state_e      state_nxt;

    assign op     = cond_op_e'(op_code);
    assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    // comparator 0: register pair; comparator 1: register against sign-extended immediate
    genvar g;
    generate
        for (g = 0; g < N_CMP; g++) begin : g_cmp
            assign cmp_b[g] = (g == 0) ? rt_val : imm_sx;
            cev_compare #(.XLEN(XLEN)) u_cmp (
                .opa     (rs_val),
                .opb     (cmp_b[g]),
                .is_eq   (cmp_eq[g]),
                .is_lt_s (cmp_lts[g]),
                .is_lt_u (cmp_ltu[g])
            );
        end
    endgenerate

    cev_flag_pick #(.FLAG_N(FLAG_N)) u_flag (
        .flags  (fcc),
        .sel    (imm[SEL_W-1:0]),
        .picked (flag_bit)
    );

    cev_decide #(.XLEN(XLEN)) u_decide (
        .op       (op),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .r_eq     (cmp_eq[0]),
        .r_lt_s   (cmp_lts[0]),
        .r_lt_u   (cmp_ltu[0]),
        .i_eq     (cmp_eq[1]),
        .i_lt_s   (cmp_lts[1]),
        .i_lt_u   (cmp_ltu[1]),
        .flag_bit (flag_bit),
        .verdict  (verdict_nxt)
    );

    // next-state: ACCEPT / CHAIN on in_valid, DRAIN otherwise
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: state_nxt = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = in_valid ? ST_DONE : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // output register: loaded only on ACCEPT/CHAIN, cleared on DRAIN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q  <= '0;
            ret_addr_q <= '0;
        end else if (in_valid) begin
            verdict_q  <= verdict_nxt;
            ret_addr_q <= verdict_nxt.lk ? (pc + XLEN'(LINK_OFS)) : '0;
        end else begin
            verdict_q  <= '0;
            ret_addr_q <= '0;
        end
    end

    always_comb begin
        res_valid = (state_q == ST_DONE);
        br_taken  = verdict_q.br;
        mv_en     = verdict_q.mv;
        trap_req  = verdict_q.tr;
        link_we   = verdict_q.lk;
        link_idx  = verdict_q.lk ? REG_IDX_W'(LINK_REG) : '0;
        link_addr = ret_addr_q;
    end
endmodule

// File: rtl/cev_chk.sv
module cev_chk #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned LINK_REG  = 31,
    parameter int unsigned LINK_OFS  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [XLEN-1:0]      pc,
    input logic                 res_valid,
    input logic                 br_taken,
    input logic                 mv_en,
    input logic                 trap_req,
    input logic                 link_we,
    input logic [REG_IDX_W-1:0] link_idx,
    input logic [XLEN-1:0]      link_addr
);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(br_taken || mv_en || trap_req || link_we));

    assert_link_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_idx == REG_IDX_W'(LINK_REG)) && br_taken);

    assert_link_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_addr == $past(pc) + XLEN'(LINK_OFS));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));

    assert_one_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_taken, mv_en, trap_req}));
endmodule

bind cond_eval_unit cev_chk #(
    .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG), .LINK_OFS(LINK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc),
    .res_valid(res_valid), .br_taken(br_taken), .mv_en(mv_en),
    .trap_req(trap_req), .link_we(link_we), .link_idx(link_idx),
    .link_addr(link_addr)
);

// File: tb/cond_eval_unit_bench.sv
`timescale 1ns/1ps
module cond_eval_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] rs_val = '0, rt_val = '0, pc = '0;
    logic [15:0] imm = '0;
    logic [7:0]  fcc = '0;
    logic        res_valid, br_taken, mv_en, trap_req, link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_addr;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    cond_eval_unit u_cond_eval_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .fcc(fcc), .pc(pc),
        .res_valid(res_valid), .br_taken(br_taken), .mv_en(mv_en),
        .trap_req(trap_req), .link_we(link_we), .link_idx(link_idx),
        .link_addr(link_addr)
    );

    // {op, rs, rt, imm, fcc, expected {br, mv, tr, lk}}
    localparam int NTAB = 12;
    localparam logic [96:0] TAB [NTAB] = '{
        {5'd1,  32'h5,        32'h5,        16'h0,    8'h00, 4'b1000}, // R2
        {5'd4,  32'h0,        32'h0,        16'h0,    8'h00, 4'b0000}, // R3 zero not > 0
        {5'd5,  32'h80000000, 32'h0,        16'h0,    8'h00, 4'b1000}, // R3
        {5'd7,  32'h0,        32'h0,        16'h0,    8'h00, 4'b1001}, // R4
        {5'd8,  32'h1,        32'h0,        16'h0,    8'h00, 4'b0000}, // R4 no link
        {5'd12, 32'h80000000, 32'h7FFFFFFF, 16'h0,    8'h00, 4'b0010}, // R5
        {5'd11, 32'h80000000, 32'h7FFFFFFF, 16'h0,    8'h00, 4'b0000}, // R5
        {5'd20, 32'h7FFFFFFF, 32'h0,        16'hFFFF, 8'h00, 4'b0010}, // R6
        {5'd17, 32'h0,        32'h0,        16'h8000, 8'h00, 4'b0010}, // R6
        {5'd21, 32'h0,        32'h0,        16'h0,    8'h01, 4'b1000}, // R7 index 0
        {5'd24, 32'h0,        32'h0,        16'h7,    8'h7F, 4'b0100}, // R7 index 7
        {5'd25, 32'h3,        32'h0,        16'h0,    8'h00, 4'b0100}  // R8
    };

    localparam logic [31:0] EDGE [4] = '{32'h7FFFFFFF, 32'h80000000, 32'h0, 32'hFFFFFFFF};

    function automatic string tag_of(input logic [4:0] op);
        if (op == 5'd1 || op == 5'd2)   return "R2";
        if (op >= 5'd3 && op <= 5'd6)   return "R3";
        if (op == 5'd7 || op == 5'd8)   return "R4";
        if (op >= 5'd9 && op <= 5'd14)  return "R5";
        if (op >= 5'd15 && op <= 5'd20) return "R6";
        if (op >= 5'd21 && op <= 5'd24) return "R7";
        if (op == 5'd25 || op == 5'd26) return "R8";
        return "R10";
    endfunction

    // reference model written from the requirements: returns {br, mv, tr, lk}
    function automatic logic [3:0] ref_eval(input logic [4:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [15:0] im,
                                            input logic [7:0] fl);
        logic [31:0] sx;
        logic        f;
        sx = {{16{im[15]}}, im};
        f  = fl[im[2:0]];
        case (op)
            5'd1:  return {(a == b), 3'b000};
            5'd2:  return {(a != b), 3'b000};
            5'd3:  return {($signed(a) >= 0), 3'b000};
            5'd4:  return {($signed(a) > 0), 3'b000};
            5'd5:  return {($signed(a) <= 0), 3'b000};
            5'd6:  return {($signed(a) < 0), 3'b000};
            5'd7:  return {($signed(a) >= 0), 2'b00, ($signed(a) >= 0)};
            5'd8:  return {($signed(a) < 0), 2'b00, ($signed(a) < 0)};
            5'd9:  return {2'b00, (a == b), 1'b0};
            5'd10: return {2'b00, (a != b), 1'b0};
            5'd11: return {2'b00, ($signed(a) >= $signed(b)), 1'b0};
            5'd12: return {2'b00, (a >= b), 1'b0};
            5'd13: return {2'b00, ($signed(a) < $signed(b)), 1'b0};
            5'd14: return {2'b00, (a < b), 1'b0};
            5'd15: return {2'b00, (a == sx), 1'b0};
            5'd16: return {2'b00, (a != sx), 1'b0};
            5'd17: return {2'b00, ($signed(a) >= $signed(sx)), 1'b0};
            5'd18: return {2'b00, (a >= sx), 1'b0};
            5'd19: return {2'b00, ($signed(a) < $signed(sx)), 1'b0};
            5'd20: return {2'b00, (a < sx), 1'b0};
            5'd21: return {f, 3'b000};
            5'd22: return {!f, 3'b000};
            5'd23: return {1'b0, f, 2'b00};
            5'd24: return {1'b0, !f, 2'b00};
            5'd25: return {1'b0, (b == 0), 2'b00};
            5'd26: return {1'b0, (b != 0), 2'b00};
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check_out(input string tag, input logic vld, input logic [3:0] exp,
                             input logic [31:0] exp_addr);
        logic [3:0]  act;
        logic [4:0]  exp_idx;
        act     = {br_taken, mv_en, trap_req, link_we};
        exp_idx = exp[0] ? 5'd31 : 5'd0;
        n_chk++;
        if (res_valid !== vld || act !== exp || link_idx !== exp_idx || link_addr !== exp_addr) begin
            n_fail++;
            $display("FAIL %s: valid=%b flags=%b idx=%0d addr=%h, expected valid=%b flags=%b idx=%0d addr=%h",
                     tag, res_valid, act, link_idx, link_addr, vld, exp, exp_idx, exp_addr);
        end
    endtask

    // drive one request at a falling edge, sample its verdict at the next falling edge
    task automatic run_one(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] im, input logic [7:0] fl, input logic [31:0] addr,
                           input logic [3:0] exp, input string tag);
        @(negedge clk);
        op_code = op; rs_val = a; rt_val = b; imm = im; fcc = fl; pc = addr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(tag, 1'b1, exp, exp[0] ? addr + 32'd8 : 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a request held at the inputs
        in_valid = 1'b1; op_code = 5'd9;
        repeat (3) @(negedge clk);
        check_out("R1 reset", 1'b0, 4'b0000, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 idle after reset", 1'b0, 4'b0000, 32'd0);

        // table of directed vectors
        for (int t = 0; t < NTAB; t++) begin
            run_one(TAB[t][96:92], TAB[t][91:60], TAB[t][59:28], TAB[t][27:12], TAB[t][11:4],
                    32'h0040_0100 + 32'(t * 4), TAB[t][3:0], tag_of(TAB[t][96:92]));
        end

        // boundary sweep of every code against the reference model
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [15:0] im;
                    logic [7:0]  fl;
                    im = EDGE[j][15:0] ^ 16'(i);
                    fl = 8'hA6 ^ 8'(j * 17);
                    run_one(5'(op), EDGE[i], EDGE[j], im, fl, EDGE[i] & 32'hFFFF_FFFC,
                            ref_eval(5'(op), EDGE[i], EDGE[j], im, fl), tag_of(5'(op)));
                end
            end
        end

        // R9: trap pulse lasts one cycle, then R1 quiet
        run_one(5'd9, 32'h1, 32'h1, 16'h0, 8'h00, 32'h100, 4'b0010, "R9 trap");
        @(negedge clk);
        check_out("R9 pulse ends", 1'b0, 4'b0000, 32'd0);

        // R9: back-to-back requests, trap then non-trapping branch
        @(negedge clk);
        op_code = 5'd9; rs_val = 32'h2; rt_val = 32'h2; pc = 32'h200; in_valid = 1'b1;
        @(negedge clk);
        check_out("R9 first of pair", 1'b1, 4'b0010, 32'd0);
        op_code = 5'd8; rs_val = 32'hFFFF_FFFF; pc = 32'h300;
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R9 second of pair (R4 link)", 1'b1, 4'b1001, 32'h308);
        @(negedge clk);
        check_out("R9 drain", 1'b0, 4'b0000, 32'd0);

        // R7: flag index 0 cleared while others set -> no branch
        run_one(5'd21, 32'h0, 32'h0, 16'h0, 8'hFE, 32'h0, 4'b0000, "R7 index 0 clear");
        // R10: unused code with everything true does nothing
        run_one(5'd31, 32'h0, 32'h0, 16'h0, 8'hFF, 32'h40, 4'b0000, "R10 unused code");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule